// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This block is the control logic of a battery-free nonvolatile SRAM. It watches the host bus (chip enable, output enable, write enable, address) and runs the transfers between the SRAM array and its shadow nonvolatile cells. There are three ways to start a transfer. A software command is a fixed run of six reads. A low pulse on a hardware store pin starts a store. A rise of the supply-good flag starts a recall.

Each transfer is timed by one cycle counter. While a transfer runs, or while power is down, the block locks the host out: writes are not passed to the array and reads return zero. A flag records whether the array has been written since the last completed transfer, and a store is skipped when that flag is clear. A hardware store first leaves the bus open for a delay window, so that host cycles already under way can finish, and only then locks the bus. The array and the nonvolatile cells are modelled by two activity outputs, `storeAct` and `recallAct`.

Top module: `nvsr_top`

## Requirements
- R1: After reset, and whenever `pwrGood` is low, `busy` is 1, `rdData` is 0 and `arrWrEn` is 0. When `pwrGood` goes high, a recall runs with `recallAct` high and `busy` high for exactly PWRUP_LEN cycles, followed by a `done` pulse. A drop of `pwrGood` makes `busy` 1 on the next cycle.
- R2: A read cycle starts when `ceN` and `oeN` are both low with `weN` high. Six read starts whose addresses are SEQ_ADDR[0] to SEQ_ADDR[5] in that order (defaults 0x3C, 0xA5, 0x0F, 0xF0, 0x5A, 0xC3) form a command. `busy` goes to 1 on the cycle after the sixth read starts.
- R3: An unlocked write (`ceN` and `weN` low) at any point, or a read whose address is not the next table entry, sends detection back to the first entry, and that attempt starts nothing. A later complete sequence is recognised.
- R4: A read cycle framed by `oeN` alone, with `ceN` held low, counts in the sequence the same as one framed by `ceN`.
- R5: With SEQ_IS_STORE=1 and the array written, an accepted command keeps `busy` high for CMD_WAIT + STORE_LEN cycles, with `storeAct` high during the last STORE_LEN of them.
- R6: A store that is due while the written flag is clear is skipped: after a command, `busy` is high for only CMD_WAIT cycles, with no `storeAct` and no `done`.
- R7: An unlocked write sets the written flag. A completed store or recall, including the power-up recall, clears it.
- R8: While `busy` is 1, a write gives `arrWrEn`=0 and does not set the written flag, and `rdData` is 0. While `busy` is 0, `rdData` equals `arrRdData`.
- R9: With SEQ_IS_STORE=0, an accepted command always runs a recall: `busy` is high for CMD_WAIT + RECALL_LEN cycles with `recallAct`, followed by a `done` pulse.
- R10: When `hwStoreN` is low for HW_MIN_LOW consecutive cycles, the bus stays open for HW_DELAY cycles. After that, if the written flag is set, a store runs with `busy` high for STORE_LEN cycles. A pulse shorter than HW_MIN_LOW cycles has no effect.
- R11: A write made during the hardware delay window is accepted (`arrWrEn`=1) and counts toward the store decision. If the flag is still clear when the window ends, no store runs.
- R12: `done` is a pulse one cycle long. It comes in the first cycle that `busy` is 0 after a completed store or recall, and never after a skipped store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrGood | input | 1 | Digital supply-good flag |
| hwStoreN | input | 1 | Hardware store request, active low |
| ceN | input | 1 | Host chip enable, active low |
| oeN | input | 1 | Host output enable, active low |
| weN | input | 1 | Host write enable, active low |
| addr | input | ADDR_W | Host address |
| arrRdData | input | DATA_W | Read data from the SRAM array |
| rdData | output | DATA_W | Read data to the host, forced to 0 while locked |
| arrWrEn | output | 1 | Write strobe forwarded to the array |
| busy | output | 1 | Host bus locked |
| done | output | 1 | One-cycle pulse when a transfer completes |
| storeAct | output | 1 | Store to the nonvolatile cells in progress |
| recallAct | output | 1 | Recall from the nonvolatile cells in progress |

## Verification
A wrong detector index shows up as a command that is missed or starts too soon. `busy` then fails to rise, or rises, on the cycle right after the sixth read. A stale or stuck written flag changes the length of the next busy period by exactly STORE_LEN cycles, and it also decides whether a `done` pulse appears. The bench therefore measures busy periods to the exact cycle and counts `done` pulses after each command. A fault in the timer or in the hardware delay path shifts the edges of `busy` by a whole number of cycles. The bench sees this on the next transfer, counting the cycles with the bus open from the end of the pulse and the locked cycles after them.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;
  localparam int SEQ_N = 6;

  typedef enum logic [2:0] {
    ST_OFF, ST_IDLE, ST_CMD, ST_HWDLY, ST_RUN
  } ctlState_e;

  typedef enum logic [2:0] {
    LEN_CMD, LEN_HW, LEN_STORE, LEN_RECALL, LEN_PWRUP
  } tmrSel_e;

  typedef struct packed {
    logic    lock;
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    dirtyClr;
  } ctlStrobe_t;

  typedef struct packed {
    logic seqHit;
    logic hwReq;
    logic tmrZero;
    logic dirty;
  } dpEvent_t;
endpackage

// File: rtl/nvsr_dp.sv
module nvsr_dp
  import nvsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [SEQ_N-1:0][ADDR_W-1:0] SEQ_ADDR =
    {8'hC3, 8'h5A, 8'hF0, 8'h0F, 8'hA5, 8'h3C},
  parameter int CMD_WAIT   = 6,
  parameter int STORE_LEN  = 40,
  parameter int RECALL_LEN = 20,
  parameter int PWRUP_LEN  = 30,
  parameter int HW_DELAY   = 10,
  parameter int HW_MIN_LOW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hwStoreN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] arrRdData,
  input  ctlStrobe_t        strobe,
  output dpEvent_t          ev,
  output logic [DATA_W-1:0] rdData,
  output logic              arrWrEn
);
  localparam int M1 = (CMD_WAIT > HW_DELAY) ? CMD_WAIT : HW_DELAY;
  localparam int M2 = (M1 > STORE_LEN) ? M1 : STORE_LEN;
  localparam int M3 = (M2 > RECALL_LEN) ? M2 : RECALL_LEN;
  localparam int MAX_LEN = (M3 > PWRUP_LEN) ? M3 : PWRUP_LEN;
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(SEQ_N);
  localparam int SLOTS = 1 << IDX_W;
  localparam int LOW_W = $clog2(HW_MIN_LOW + 1);

  // host bus decode
  logic rdAct, wrAct, rdActQ, rdStart;
  assign rdAct   = !ceN && !oeN && weN;
  assign wrAct   = !ceN && !weN;
  assign rdStart = rdAct && !rdActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdActQ <= 1'b0;
    else       rdActQ <= rdAct;
  end

  assign arrWrEn = wrAct && !strobe.lock;
  assign rdData  = strobe.lock ? '0 : arrRdData;

  // command sequence detector
  logic [SLOTS-1:0] seqMatch;
  logic [IDX_W-1:0] seqIdx;
  logic             lastIdx;

  for (genvar i = 0; i < SLOTS; i++) begin : g_match
    if (i < SEQ_N) begin : g_live
      assign seqMatch[i] = (addr == SEQ_ADDR[i]);
    end else begin : g_pad
      assign seqMatch[i] = 1'b0;
    end
  end

  assign lastIdx = (seqIdx == IDX_W'(SEQ_N - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqIdx <= '0;
    end else if (wrAct || strobe.lock) begin
      seqIdx <= '0;
    end else if (rdStart) begin
      if (seqMatch[seqIdx] && !lastIdx) seqIdx <= seqIdx + 1'b1;
      else                              seqIdx <= '0;
    end
  end

  assign ev.seqHit = rdStart && !strobe.lock && seqMatch[seqIdx] && lastIdx;

  // written-since-last-transfer flag
  logic dirty;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       dirty <= 1'b0;
    else if (strobe.dirtyClr)        dirty <= 1'b0;
    else if (wrAct && !strobe.lock)  dirty <= 1'b1;
  end
  assign ev.dirty = dirty;

  // hardware store pulse qualifier
  logic [LOW_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              lowCnt <= '0;
    else if (hwStoreN)                      lowCnt <= '0;
    else if (lowCnt != LOW_W'(HW_MIN_LOW))  lowCnt <= lowCnt + 1'b1;
  end
  assign ev.hwReq = !hwStoreN && (lowCnt == LOW_W'(HW_MIN_LOW - 1));

  // shared operation timer
  logic [CNT_W-1:0] tmrCnt, loadVal;
  always_comb begin
    case (strobe.tmrSel)
      LEN_CMD:    loadVal = CNT_W'(CMD_WAIT - 1);
      LEN_HW:     loadVal = CNT_W'(HW_DELAY - 1);
      LEN_STORE:  loadVal = CNT_W'(STORE_LEN - 1);
      LEN_RECALL: loadVal = CNT_W'(RECALL_LEN - 1);
      LEN_PWRUP:  loadVal = CNT_W'(PWRUP_LEN - 1);
      default:    loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tmrCnt <= '0;
    else if (strobe.tmrLoad) tmrCnt <= loadVal;
    else if (tmrCnt != '0)   tmrCnt <= tmrCnt - 1'b1;
  end
  assign ev.tmrZero = (tmrCnt == '0);

  // assertions
  assert_dirty_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirtyClr |=> !ev.dirty);
  assert_write_marks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && !strobe.dirtyClr) |=> ev.dirty);
  assert_hwreq_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    ev.hwReq |=> !ev.hwReq);
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    seqIdx < IDX_W'(SEQ_N));
  assert_lock_clears_idx_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lock |=> (seqIdx == '0));
endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
  import nvsr_pkg::*;
#(
  parameter bit SEQ_IS_STORE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  dpEvent_t   ev,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       storeAct,
  output logic       recallAct
);
  ctlState_e state, stNext;
  logic      opStore, opNext;

  always_comb begin
    stNext        = state;
    opNext        = opStore;
    strobe        = '0;
    strobe.lock   = 1'b1;
    strobe.tmrSel = LEN_CMD;
    case (state)
      ST_OFF: begin
        if (pwrGood) begin
          stNext         = ST_RUN;
          opNext         = 1'b0;
          strobe.tmrLoad = 1'b1;
          strobe.tmrSel  = LEN_PWRUP;
        end
      end
      ST_IDLE: begin
        strobe.lock = 1'b0;
        if (ev.hwReq) begin
          stNext         = ST_HWDLY;
          strobe.tmrLoad = 1'b1;
          strobe.tmrSel  = LEN_HW;
        end else if (ev.seqHit) begin
          stNext         = ST_CMD;
          strobe.tmrLoad = 1'b1;
          strobe.tmrSel  = LEN_CMD;
        end
      end
      ST_CMD: begin
        if (ev.tmrZero) begin
          if (SEQ_IS_STORE && !ev.dirty) begin
            stNext = ST_IDLE;
          end else begin
            stNext         = ST_RUN;
            opNext         = SEQ_IS_STORE;
            strobe.tmrLoad = 1'b1;
            strobe.tmrSel  = SEQ_IS_STORE ? LEN_STORE : LEN_RECALL;
          end
        end
      end
      ST_HWDLY: begin
        strobe.lock = 1'b0;
        if (ev.tmrZero) begin
          if (ev.dirty) begin
            stNext         = ST_RUN;
            opNext         = 1'b1;
            strobe.tmrLoad = 1'b1;
            strobe.tmrSel  = LEN_STORE;
          end else begin
            stNext = ST_IDLE;
          end
        end
      end
      ST_RUN: begin
        if (ev.tmrZero) begin
          stNext          = ST_IDLE;
          strobe.dirtyClr = 1'b1;
        end
      end
      default: stNext = ST_OFF;
    endcase
    if (!pwrGood) begin
      stNext          = ST_OFF;
      strobe.tmrLoad  = 1'b0;
      strobe.dirtyClr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      opStore <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= stNext;
      opStore <= opNext;
      done    <= (state == ST_RUN) && ev.tmrZero && pwrGood;
    end
  end

  assign busy      = (state != ST_IDLE) && (state != ST_HWDLY);
  assign storeAct  = (state == ST_RUN) && opStore;
  assign recallAct = (state == ST_RUN) && !opStore;

  // assertions
  assert_store_needs_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeAct) |-> $past(ev.dirty));
  assert_power_drop_lock_R1: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> busy);
  assert_seq_locks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ev.seqHit && !ev.hwReq && pwrGood) |=> busy);
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_after_run_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(state) == ST_RUN));
  assert_hw_window_open_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ev.hwReq && pwrGood) |=> !busy);
endmodule

// File: rtl/nvsr_top.sv
module nvsr_top
  import nvsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [SEQ_N-1:0][ADDR_W-1:0] SEQ_ADDR =
    {8'hC3, 8'h5A, 8'hF0, 8'h0F, 8'hA5, 8'h3C},
  parameter bit SEQ_IS_STORE = 1'b1,
  parameter int CMD_WAIT   = 6,
  parameter int STORE_LEN  = 40,
  parameter int RECALL_LEN = 20,
  parameter int PWRUP_LEN  = 30,
  parameter int HW_DELAY   = 10,
  parameter int HW_MIN_LOW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              hwStoreN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              arrWrEn,
  output logic              busy,
  output logic              done,
  output logic              storeAct,
  output logic              recallAct
);
  ctlStrobe_t strobe;
  dpEvent_t   ev;

  nvsr_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_ADDR(SEQ_ADDR),
    .CMD_WAIT(CMD_WAIT), .STORE_LEN(STORE_LEN), .RECALL_LEN(RECALL_LEN),
    .PWRUP_LEN(PWRUP_LEN), .HW_DELAY(HW_DELAY), .HW_MIN_LOW(HW_MIN_LOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .hwStoreN(hwStoreN), .addr(addr), .arrRdData(arrRdData),
    .strobe(strobe), .ev(ev), .rdData(rdData), .arrWrEn(arrWrEn)
  );

  nvsr_ctrl #(
    .SEQ_IS_STORE(SEQ_IS_STORE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .ev(ev), .strobe(strobe),
    .busy(busy), .done(done), .storeAct(storeAct), .recallAct(recallAct)
  );
endmodule

// File: tb/sim_nvsr_top.sv
`timescale 1ns/1ps
module sim_nvsr_top;
  localparam int CMD_WAIT = 6, STORE_LEN = 40, RECALL_LEN = 20;
  localparam int PWRUP_LEN = 30, HW_DELAY = 10, HW_MIN_LOW = 3;
  localparam logic [7:0] SEQ [6] = '{8'h3C, 8'hA5, 8'h0F, 8'hF0, 8'h5A, 8'hC3};

  logic clk = 1'b0, rstN = 1'b0, pwrGood = 1'b0, hwStoreN = 1'b1;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [7:0] addr = '0, arrRdData = '0;
  logic [7:0] rdData, rdData1;
  logic arrWrEn, busy, done, storeAct, recallAct;
  logic arrWrEn1, busy1, done1, storeAct1, recallAct1;
  int nChecks = 0, nErr = 0;

  always #2.5 clk = ~clk;

  nvsr_top #(.CMD_WAIT(CMD_WAIT), .STORE_LEN(STORE_LEN), .RECALL_LEN(RECALL_LEN),
    .PWRUP_LEN(PWRUP_LEN), .HW_DELAY(HW_DELAY), .HW_MIN_LOW(HW_MIN_LOW),
    .SEQ_IS_STORE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .hwStoreN(hwStoreN), .ceN(ceN),
    .oeN(oeN), .weN(weN), .addr(addr), .arrRdData(arrRdData), .rdData(rdData),
    .arrWrEn(arrWrEn), .busy(busy), .done(done), .storeAct(storeAct),
    .recallAct(recallAct));

  nvsr_top #(.CMD_WAIT(CMD_WAIT), .STORE_LEN(STORE_LEN), .RECALL_LEN(RECALL_LEN),
    .PWRUP_LEN(PWRUP_LEN), .HW_DELAY(HW_DELAY), .HW_MIN_LOW(HW_MIN_LOW),
    .SEQ_IS_STORE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .hwStoreN(hwStoreN), .ceN(ceN),
    .oeN(oeN), .weN(weN), .addr(addr), .arrRdData(arrRdData), .rdData(rdData1),
    .arrWrEn(arrWrEn1), .busy(busy1), .done(done1), .storeAct(storeAct1),
    .recallAct(recallAct1));

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ceRead(input logic [7:0] a);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic oeRead(input logic [7:0] a);
    @(negedge clk); addr = a; oeN = 1'b0;
    @(negedge clk); oeN = 1'b1;
  endtask

  task automatic hostWrite(input logic [7:0] a);
    @(negedge clk); addr = a; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic runSeq();
    for (int i = 0; i < 6; i++) ceRead(SEQ[i]);
  endtask

  task automatic hwPulse(input int n);
    @(negedge clk); hwStoreN = 1'b0;
    repeat (n) @(negedge clk);
    hwStoreN = 1'b1;
  endtask

  // count busy cycles of u0 from the current negedge, plus done pulses and activity
  task automatic measure(output int nb, output int nd, output int ns, output int nr);
    nb = 0; nd = 0; ns = 0; nr = 0;
    while (busy) begin
      nb++;
      if (storeAct) ns++;
      if (recallAct) nr++;
      @(negedge clk);
      if (done) nd++;
    end
  endtask

  task automatic watchIdle(input int cyc, output int nb, output int nd);
    nb = 0; nd = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (busy) nb++;
      if (done) nd++;
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 busy in reset/off", busy, 1);
    chk("R1 done low in off", done, 0);
    arrRdData = 8'hA7; ceN = 1'b0; oeN = 1'b0; #1;
    chk("R1 rdData zero in off", rdData, 0);
    oeN = 1'b1; weN = 1'b0; #1;
    chk("R1 write blocked in off", arrWrEn, 0);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic tPowerUp();
    int nb, nd, ns, nr;
    @(negedge clk); pwrGood = 1'b1;
    @(negedge clk);
    measure(nb, nd, ns, nr);
    chk("R1 power-up recall length", nb, PWRUP_LEN);
    chk("R1 recallAct during power-up", nr, PWRUP_LEN);
    chk("R12 done after power-up recall", nd, 1);
    @(negedge clk);
    chk("R12 done one cycle", done, 0);
  endtask

  // clean array after power-up: u0 skips its store, u1 runs a recall
  task automatic tRecallMode();
    int n0 = 0, n1 = 0, d0 = 0, d1 = 0, r1 = 0, s0 = 0;
    runSeq();
    while (busy || busy1) begin
      if (busy) n0++;
      if (busy1) n1++;
      if (recallAct1) r1++;
      if (storeAct) s0++;
      @(negedge clk);
      if (done) d0++;
      if (done1) d1++;
    end
    chk("R9 recall-mode busy length", n1, CMD_WAIT + RECALL_LEN);
    chk("R9 recall-mode recallAct", r1, RECALL_LEN);
    chk("R9 recall-mode done", d1, 1);
    chk("R7 power-up recall cleared flag, store skipped", n0, CMD_WAIT);
    chk("R6 skipped store no storeAct", s0, 0);
    chk("R6 skipped store no done", d0, 0);
  endtask

  task automatic tStore();
    int nb, nd, ns, nr;
    @(negedge clk); addr = 8'h10; ceN = 1'b0; weN = 1'b0; #1;
    chk("R7 idle write forwarded", arrWrEn, 1);
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
    runSeq();
    measure(nb, nd, ns, nr);
    chk("R5 store busy length", nb, CMD_WAIT + STORE_LEN);
    chk("R5 storeAct length", ns, STORE_LEN);
    chk("R12 done after store", nd, 1);
    @(negedge clk);
    chk("R12 done drops", done, 0);
    runSeq();
    measure(nb, nd, ns, nr);
    chk("R7 flag cleared by store, second store skipped", nb, CMD_WAIT);
    chk("R12 no done after skip", nd, 0);
  endtask

  task automatic tAborts();
    int nb, nd, ns, nr;
    ceRead(SEQ[0]); ceRead(SEQ[1]); ceRead(SEQ[2]);
    hostWrite(8'h20);
    ceRead(SEQ[3]); ceRead(SEQ[4]); ceRead(SEQ[5]);
    measure(nb, nd, ns, nr);
    chk("R3 write aborts sequence", nb, 0);
    ceRead(SEQ[0]); ceRead(SEQ[1]); ceRead(SEQ[2]); ceRead(8'h77);
    ceRead(SEQ[3]); ceRead(SEQ[4]); ceRead(SEQ[5]);
    measure(nb, nd, ns, nr);
    chk("R3 wrong address aborts sequence", nb, 0);
    runSeq();
    measure(nb, nd, ns, nr);
    chk("R3 full sequence after abort runs store", nb, CMD_WAIT + STORE_LEN);
  endtask

  task automatic tOeFramed();
    int nb, nd, ns, nr;
    @(negedge clk); ceN = 1'b0;
    for (int i = 0; i < 6; i++) oeRead(SEQ[i]);
    ceN = 1'b1;
    measure(nb, nd, ns, nr);
    chk("R4 OE-framed sequence accepted", nb, CMD_WAIT);
  endtask

  task automatic tLockout();
    int nb, nd, ns, nr;
    @(negedge clk); arrRdData = 8'h5A; addr = 8'h77; ceN = 1'b0; oeN = 1'b0; #1;
    chk("R8 idle read passes array data", rdData, 8'h5A);
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;
    hostWrite(8'h30);
    runSeq();
    ceN = 1'b0; oeN = 1'b0; #1;
    chk("R8 read while busy returns zero", rdData, 0);
    @(negedge clk); oeN = 1'b1; weN = 1'b0; #1;
    chk("R8 write while busy blocked", arrWrEn, 0);
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
    measure(nb, nd, ns, nr);
    chk("R5 store length with host activity", nb + 2, CMD_WAIT + STORE_LEN);
    runSeq();
    measure(nb, nd, ns, nr);
    chk("R8 locked write left flag clear", nb, CMD_WAIT);
  endtask

  task automatic tHwStore();
    int nb, nd, ns, nr, nLow;
    hwPulse(HW_MIN_LOW);
    watchIdle(HW_DELAY + STORE_LEN + 4, nb, nd);
    chk("R11 hw store with clean flag skipped", nb, 0);
    chk("R11 no done on skipped hw store", nd, 0);
    hostWrite(8'h40);
    hwPulse(HW_MIN_LOW - 1);
    watchIdle(HW_DELAY + STORE_LEN + 4, nb, nd);
    chk("R10 short pulse ignored", nb, 0);
    hwPulse(HW_MIN_LOW);
    nLow = 0;
    while (!busy) begin nLow++; @(negedge clk); end
    chk("R10 delay window length", nLow, HW_DELAY);
    measure(nb, nd, ns, nr);
    chk("R10 hw store length", nb, STORE_LEN);
    chk("R10 hw store done", nd, 1);
    hwPulse(HW_MIN_LOW);
    addr = 8'h50; ceN = 1'b0; weN = 1'b0; #1;
    chk("R11 write in delay window accepted", arrWrEn, 1);
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
    nLow = 1;
    while (!busy) begin nLow++; @(negedge clk); end
    chk("R11 window unchanged by write", nLow, HW_DELAY);
    measure(nb, nd, ns, nr);
    chk("R11 write in window makes store run", ns, STORE_LEN);
  endtask

  task automatic tPowerDrop();
    int nb, nd, ns, nr;
    @(negedge clk); pwrGood = 1'b0;
    @(negedge clk);
    chk("R1 power drop locks bus", busy, 1);
    pwrGood = 1'b1;
    @(negedge clk);
    measure(nb, nd, ns, nr);
    chk("R1 recall after power returns", nr, PWRUP_LEN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tPowerUp();
    tRecallMode();
    tStore();
    tAborts();
    tOeFramed();
    tLockout();
    tHwStore();
    tPowerDrop();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule